// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Cell

This block is the interrupt front end of a peripheral that sits in a serial priority chain. Several level-sensitive source bits are filtered through a software mask register and combined into one active-low request line to the processor. An active-low acknowledge input marks the request as being serviced. While the service flag is set, both the cell's own request and every cell further down the chain stay blocked. Only an explicit software command clears the flag.

Priority is set by position in the chain. The first cell has its enable input tied high. Each later cell takes its enable input from the enable output of the cell ahead of it. A cell that is requesting or being serviced drives its enable output low, and this shuts out every cell behind it. A mode input selects chain operation. With the mode off, the enable input has no effect, the enable output stays low, and the mask alone gates the sources.

One write strobe with a one-bit select does two jobs. It loads the mask, or it issues the clear-in-service command. The request and enable outputs are both registered, so each output follows its inputs by one clock.

Top module: `irq_chain_cell`

## Requirements
- R1: In chain mode with the enable input high, a source whose mask bit is set drives the request output low on the clock edge after it is seen.
- R2: Mask bit i enables source bit i. The mask is loaded from the write data on an edge where the write strobe is high with select 0. A source whose mask bit is clear never asserts the request.
- R3: In chain mode, a low enable input holds the request output high whatever the sources and mask are.
- R4: In chain mode, the enable output is high one edge after the cell sees three conditions: the enable input high, no unmasked source active, and the service flag clear. Otherwise the enable output is low.
- R5: Once set, the service flag holds the enable output low after the acknowledge returns high and after the sources go idle. The flag clears on an edge where the write strobe is high with select 1, and the enable output may then rise.
- R6: Both the request output and the acknowledge input are active low. After reset the request output is high.
- R7: With chain mode off, the enable input has no effect on the request, and the enable output is held low.
- R8: The service flag is set on a synchronously detected high-to-low change of the acknowledge. Three conditions must hold at that edge: the request output is low, the cell is enabled (chain mode off, or the enable input high), and no clear command is present. An acknowledge that falls while the cell is not enabled is ignored.
- R9: While the service flag is set, the request output is held high. A source that is still active asserts the request again one edge after the flag clears.
- R10: A synchronous reset clears the mask and the service flag and drives the request output high. In chain mode the enable output equals the enable input after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | NSRC | Level-sensitive interrupt source bits |
| chain_mode_i | input | 1 | 1 selects daisy-chain operation |
| en_in_i | input | 1 | Chain enable from the higher-priority neighbour |
| ack_n_i | input | 1 | Interrupt acknowledge, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | 0 loads the mask, 1 clears the service flag |
| wr_data_i | input | NSRC | Mask value to load |
| irq_n_o | output | 1 | Interrupt request, active low, registered |
| en_out_o | output | 1 | Chain enable to the lower-priority neighbour, registered |

## Verification
The assertions assume that every input is synchronous to the clock and settles before each edge. They also assume that the acknowledge is driven only by this cell's own processor, so a falling acknowledge has meaning only when it meets a low request. The bench changes all inputs one time unit after a rising edge and holds each value across the next edge. It never issues a clear command on the same edge as an acknowledge falling edge. The flag-set check therefore looks only at the enable gating and the request state.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  typedef enum logic {
    WSEL_MASK    = 1'b0,
    WSEL_IUS_CLR = 1'b1
  } wr_sel_e;

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [NSRC-1:0] wr_data_i,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] mask_q,
  output logic            pending_o
);
  import irq_chain_pkg::*;

  logic [NSRC-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (wr_en_i && wr_sel_i == WSEL_MASK) begin
      mask_q <= wr_data_i;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign hit[i] = src_i[i] & mask_q[i];
  end

  assign pending_o = |hit;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(mask_q)); // R2

endmodule

// File: rtl/irq_ius_tracker.sv
module irq_ius_tracker (
  input  logic clk,
  input  logic rst,
  input  logic ack_n_i,
  input  logic req_active_i,
  input  logic gate_i,
  input  logic clr_cmd_i,
  output logic ius_q
);

  logic ack_prev_q;
  logic ack_fall;

  always_ff @(posedge clk) begin
    if (rst) ack_prev_q <= 1'b1;
    else     ack_prev_q <= ack_n_i;
  end

  assign ack_fall = ack_prev_q & ~ack_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ius_q <= 1'b0;
    end else if (clr_cmd_i) begin
      ius_q <= 1'b0;
    end else if (ack_fall && req_active_i && gate_i) begin
      ius_q <= 1'b1;
    end
  end

  AST_IUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ius_q && !clr_cmd_i) |=> ius_q); // R5

  AST_IUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_cmd_i |=> !ius_q); // R5

  AST_IUS_SET_GATED: assert property (@(posedge clk) disable iff (rst)
    (!ius_q && !(req_active_i && gate_i)) |=> !ius_q); // R8

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic chain_mode_i,
  input  logic en_in_i,
  input  logic gate_i,
  input  logic pending_i,
  input  logic ius_i,
  output logic irq_n_q,
  output logic en_out_q
);

  logic req_now;
  logic pass_now;

  assign req_now  = pending_i & gate_i & ~ius_i;
  assign pass_now = chain_mode_i & en_in_i & ~pending_i & ~ius_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_q  <= 1'b1;
      en_out_q <= chain_mode_i & en_in_i;
    end else begin
      irq_n_q  <= ~req_now;
      en_out_q <= pass_now;
    end
  end

  AST_IUS_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
    ius_i |=> irq_n_q); // R9

  AST_IUS_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (rst)
    ius_i |=> !en_out_q); // R5

  AST_NONCHAIN_EO_LOW: assert property (@(posedge clk) disable iff (rst)
    !chain_mode_i |=> !en_out_q); // R7

  AST_EN_LOW_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    (chain_mode_i && !en_in_i) |=> (irq_n_q && !en_out_q)); // R3

  AST_NO_PENDING_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pending_i |=> irq_n_q); // R2

endmodule

// File: rtl/irq_chain_cell.sv
module irq_chain_cell #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            chain_mode_i,
  input  logic            en_in_i,
  input  logic            ack_n_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [NSRC-1:0] wr_data_i,
  output logic            irq_n_o,
  output logic            en_out_o
);
  import irq_chain_pkg::*;

  logic [NSRC-1:0] mask_q;
  logic            pending;
  logic            gate;
  logic            clr_cmd;
  logic            ius_q;
  logic            irq_n_q;
  logic            en_out_q;

  assign gate    = ~chain_mode_i | en_in_i;
  assign clr_cmd = wr_en_i & (wr_sel_i == WSEL_IUS_CLR);

  irq_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .src_i     (src_i),
    .mask_q    (mask_q),
    .pending_o (pending)
  );

  irq_ius_tracker u_ius (
    .clk          (clk),
    .rst          (rst),
    .ack_n_i      (ack_n_i),
    .req_active_i (~irq_n_q),
    .gate_i       (gate),
    .clr_cmd_i    (clr_cmd),
    .ius_q        (ius_q)
  );

  irq_out_stage u_out (
    .clk          (clk),
    .rst          (rst),
    .chain_mode_i (chain_mode_i),
    .en_in_i      (en_in_i),
    .gate_i       (gate),
    .pending_i    (pending),
    .ius_i        (ius_q),
    .irq_n_q      (irq_n_q),
    .en_out_q     (en_out_q)
  );

  assign irq_n_o  = irq_n_q;
  assign en_out_o = en_out_q;

  AST_REQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    ((src_i & mask_q) == '0) |=> irq_n_o); // R2

  AST_REQ_EXCLUDES_PASS: assert property (@(posedge clk) disable iff (rst)
    !(!irq_n_o && en_out_o)); // R4

endmodule

// File: tb/irq_chain_cell_test.sv
`timescale 1ns/100ps
module irq_chain_cell_test;

  localparam int NSRC = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic [NSRC-1:0] src;
  logic            chain_mode;
  logic            en_in;
  logic            ack_n;
  logic            wr_en;
  logic            wr_sel;
  logic [NSRC-1:0] wr_data;
  logic            irq_n;
  logic            en_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_chain_cell #(.NSRC(NSRC)) uut (
    .clk          (clk),
    .rst          (rst),
    .src_i        (src),
    .chain_mode_i (chain_mode),
    .en_in_i      (en_in),
    .ack_n_i      (ack_n),
    .wr_en_i      (wr_en),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data),
    .irq_n_o      (irq_n),
    .en_out_o     (en_out)
  );

  // {mode, en_in, mask[3:0], src[3:0], exp_irq_n, exp_en_out}
  localparam logic [11:0] VEC [8] = '{
    {1'b1, 1'b1, 4'hF, 4'h0, 1'b1, 1'b1},
    {1'b1, 1'b1, 4'h3, 4'h4, 1'b1, 1'b1},
    {1'b1, 1'b1, 4'h3, 4'h2, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'hF, 4'hF, 1'b1, 1'b0},
    {1'b1, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0},
    {1'b0, 1'b0, 4'h8, 4'h8, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'h0, 4'hF, 1'b1, 1'b0},
    {1'b1, 1'b1, 4'h0, 4'hF, 1'b1, 1'b1}
  };

  localparam string VEC_REQ [8] = '{
    "R4", "R2", "R1", "R3", "R4", "R7", "R7", "R2"
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic write(input logic sel, input logic [NSRC-1:0] data);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = data;
    tick();
    wr_en   = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; src = '0; chain_mode = 1'b1; en_in = 1'b1; ack_n = 1'b1;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    tick(); tick();
    // R10 / R6: reset state
    check("R6", "irq_n in reset", irq_n, 1'b1);
    check("R10", "en_out follows en_in high", en_out, 1'b1);
    en_in = 1'b0;
    tick();
    check("R10", "en_out follows en_in low", en_out, 1'b0);
    rst = 1'b0;
    tick();
    check("R10", "mask cleared, irq idle", irq_n, 1'b1);

    // table of patterns, no acknowledge
    for (int k = 0; k < 8; k++) begin
      write(1'b0, VEC[k][9:6]);
      chain_mode = VEC[k][11];
      en_in      = VEC[k][10];
      src        = VEC[k][5:2];
      tick();
      check(VEC_REQ[k], $sformatf("vec%0d irq_n", k), irq_n, VEC[k][1]);
      check(VEC_REQ[k], $sformatf("vec%0d en_out", k), en_out, VEC[k][0]);
    end

    // acknowledge handshake in chain mode
    chain_mode = 1'b1; en_in = 1'b1; src = 4'h0;
    write(1'b0, 4'h1);
    src = 4'h1;
    tick();
    check("R1", "request before ack", irq_n, 1'b0);
    ack_n = 1'b0;
    tick();
    tick();
    check("R9", "request dropped after ack", irq_n, 1'b1);
    check("R5", "chain blocked after ack", en_out, 1'b0);
    ack_n = 1'b1;
    tick(); tick(); tick();
    check("R9", "source held pending while in service", irq_n, 1'b1);
    src = 4'h0;
    tick(); tick();
    check("R5", "chain still blocked with sources idle", en_out, 1'b0);
    src = 4'h1;
    tick();
    write(1'b1, 4'h0);
    tick();
    check("R9", "pending source re-raised after clear", irq_n, 1'b0);
    check("R4", "chain low while pending", en_out, 1'b0);
    src = 4'h0;
    tick();
    check("R5", "chain released after clear", en_out, 1'b1);
    check("R1", "request idle with no source", irq_n, 1'b1);

    // acknowledge while enable input low is ignored
    src = 4'h1;
    tick();
    check("R1", "request asserted again", irq_n, 1'b0);
    en_in = 1'b0; ack_n = 1'b0;
    tick();
    check("R3", "enable low drops request", irq_n, 1'b1);
    en_in = 1'b1;
    tick();
    check("R8", "ack ignored when disabled", irq_n, 1'b0);
    ack_n = 1'b1;
    tick();
    check("R8", "still requesting, no service flag", irq_n, 1'b0);

    // R7: non-chain mode acknowledge and enable input ignored
    chain_mode = 1'b0; en_in = 1'b0;
    tick();
    check("R7", "request with enable input low", irq_n, 1'b0);
    check("R7", "enable output held low", en_out, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule